// File: doc/BRIEF.md
# Channel Start and Hop Synchronization Controller

This block decides when one receive channel leaves its low-power sleep state and when a new tuning frequency takes effect. Software starts either event through a small register write port. Hardware starts them with a pulse on one of four sync inputs. Each event has its own programmable hold-off. A trigger loads that hold-off into a down-counter, and the event fires in the cycle where the counter holds one.

A fired start clears the sleep bit. If the channel is already awake, the same start instead produces a filter-phase realignment strobe, which lets several channels be lined up to one sample clock. A fired hop produces a strobe that tells the tuning datapath to commit its shadowed frequency word. A global sleep write, shared by all channels, loads this channel's sleep bit from its own lane of a per-channel vector.

Register map (write only, `wr_addr`):

| Address | Contents |
|---|---|
| 0 | bit 0: sleep |
| 1 | bit 0: start trigger; bit 1: hop trigger (no storage) |
| 2 | bit 0: pin start enable; bit 1: pin hop enable; bits 3:2: sync pin select |
| 3 | start hold-off value |
| 4 | hop hold-off value |

Top module: `chan_sync_ctrl`

## Requirements
- R1: After reset, `sleep` is 1, all hold-off values and enables are 0, and `start_pulse`, `hop_pulse` and `phase_adj_pulse` are low.
- R2: A write to address 0 loads `sleep` from `wr_data[0]`. A cycle with `gsleep_wr` high loads `sleep` from `gsleep_data[CHAN_ID]`. The new value shows from the cycle after the write. The global write takes priority over the local write, and both take priority over a start event.
- R3: A write to address 1 with bit 0 set loads the start counter with the value V from address 3. `start_pulse` is then high for exactly one cycle, V clock edges after the edge that samples the write. With V=1 this is the cycle right after the write.
- R4: A write to address 1 with bit 1 set does the same for the hop counter, using the value from address 4, and produces `hop_pulse`.
- R5: A trigger whose hold-off value is 0 produces no pulse and leaves a countdown already in progress unchanged.
- R6: When a start fires while `sleep` is 1, `sleep` reads 0 from the next cycle, unless a sleep write lands on the same edge.
- R7: `phase_adj_pulse` is high together with `start_pulse` exactly when the start fires while `sleep` is 0, and `sleep` stays 0. A start that fires during sleep gives no `phase_adj_pulse`.
- R8: Address 2 enables pin triggers and selects pin `wr_data[3:2]`. A rising edge on the selected `sync_in` pin, first sampled on edge E, loads each enabled counter at edge E+2. The pulse therefore follows V+2 edges after E.
- R9: One rising edge on a sync pin gives exactly one trigger, however long the pin stays high. Pins other than the selected one, and pin edges whose enable is 0, have no effect.
- R10: A trigger that arrives while a counter is still counting reloads that counter, so the pulse comes V edges after the latest trigger.
- R11: The start and hop counters run independently. A single write with both bits set fires each one after its own hold-off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| gsleep_wr | input | 1 | Global sleep write strobe shared by all channels |
| gsleep_data | input | 4 | Per-channel sleep values; lane CHAN_ID belongs to this channel |
| sync_in | input | 4 | Asynchronous hardware sync pins |
| sleep | output | 1 | Channel low-power state (1 = asleep) |
| start_pulse | output | 1 | One-cycle start event |
| hop_pulse | output | 1 | One-cycle frequency commit event |
| phase_adj_pulse | output | 1 | One-cycle filter realignment event for an awake channel |

## Verification
A corrupted count shows up at the ports as a strobe that is early, late, doubled or missing. This is visible within V+2 cycles of the trigger, so sweeping V over small values pins the error to an exact cycle. A wrong sleep state shows one cycle after the edge that should have changed it. It also shows as a `phase_adj_pulse` that appears or vanishes on the next start. A faulty edge detector shows as extra strobes while a pin is held high, or as no strobe at all.

// File: rtl/chan_sync_pkg.sv
package chan_sync_pkg;

  localparam int REG_ADDR_W = 3;

  // register addresses
  localparam logic [REG_ADDR_W-1:0] ADDR_SLEEP    = 3'd0;
  localparam logic [REG_ADDR_W-1:0] ADDR_SOFT     = 3'd1;
  localparam logic [REG_ADDR_W-1:0] ADDR_PIN_CFG  = 3'd2;
  localparam logic [REG_ADDR_W-1:0] ADDR_START_HO = 3'd3;
  localparam logic [REG_ADDR_W-1:0] ADDR_HOP_HO   = 3'd4;

  // bit positions inside the trigger and pin configuration words
  localparam int BIT_START  = 0;
  localparam int BIT_HOP    = 1;
  localparam int BIT_SEL_LO = 2;

  // event lanes of the counter array
  localparam int EV_START = 0;
  localparam int EV_HOP   = 1;
  localparam int NUM_EV   = 2;

  // Sleep resolution: global write, then local write, then a wake event.
  function automatic logic sleep_next(logic cur, logic g_wr, logic g_val,
                                      logic l_wr, logic l_val, logic wake);
    if (g_wr) return g_val;
    if (l_wr) return l_val;
    if (wake) return 1'b0;
    return cur;
  endfunction

endpackage

// File: rtl/sync_pin_front.sv
module sync_pin_front #(
  parameter int NUM_SYNC    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_SYNC-1:0] pins,
  output logic [NUM_SYNC-1:0] rise
);

  localparam int LAST = SYNC_STAGES - 1;

  for (genvar p = 0; p < NUM_SYNC; p++) begin : g_pin
    logic [SYNC_STAGES-1:0] stage_q;
    logic                   prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q <= '0;
        prev_q  <= 1'b0;
      end else begin
        stage_q <= {stage_q[SYNC_STAGES-2:0], pins[p]};
        prev_q  <= stage_q[LAST];
      end
    end

    assign rise[p] = stage_q[LAST] & ~prev_q;
  end

endmodule

// File: rtl/holdoff_counter.sv
module holdoff_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig,
  input  logic [CNT_W-1:0] load_val,
  output logic             fire,
  output logic             busy
);

  logic [CNT_W-1:0] cnt_q;

  // A zero value suppresses the trigger; otherwise the trigger reloads.
  function automatic logic [CNT_W-1:0] count_next(logic [CNT_W-1:0] cnt,
                                                  logic t,
                                                  logic [CNT_W-1:0] val);
    if (t && (val != '0)) return val;
    if (cnt != '0) return cnt - CNT_W'(1);
    return cnt;
  endfunction

  function automatic logic count_fires(logic [CNT_W-1:0] cnt);
    return cnt == CNT_W'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= count_next(cnt_q, trig, load_val);
  end

  assign fire = count_fires(cnt_q);
  assign busy = (cnt_q != '0);

endmodule

// File: rtl/chan_sync_ctrl.sv
module chan_sync_ctrl
  import chan_sync_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int DATA_W      = 16,
  parameter int NUM_SYNC    = 4,
  parameter int SYNC_STAGES = 2,
  parameter int NUM_CHAN    = 4,
  parameter int CHAN_ID     = 0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [REG_ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0]     wr_data,
  input  logic                  gsleep_wr,
  input  logic [NUM_CHAN-1:0]   gsleep_data,
  input  logic [NUM_SYNC-1:0]   sync_in,
  output logic                  sleep,
  output logic                  start_pulse,
  output logic                  hop_pulse,
  output logic                  phase_adj_pulse
);

  localparam int SEL_W = (NUM_SYNC > 1) ? $clog2(NUM_SYNC) : 1;

  function automatic logic lane_of(logic [NUM_CHAN-1:0] vec, int idx);
    return vec[idx];
  endfunction

  // write decode
  logic wr_sleep, wr_soft, wr_pin_cfg, wr_start_ho, wr_hop_ho;
  assign wr_sleep    = wr_en && (wr_addr == ADDR_SLEEP);
  assign wr_soft     = wr_en && (wr_addr == ADDR_SOFT);
  assign wr_pin_cfg  = wr_en && (wr_addr == ADDR_PIN_CFG);
  assign wr_start_ho = wr_en && (wr_addr == ADDR_START_HO);
  assign wr_hop_ho   = wr_en && (wr_addr == ADDR_HOP_HO);

  // configuration state
  logic [CNT_W-1:0] start_ho_q, hop_ho_q;
  logic             pin_start_en_q, pin_hop_en_q;
  logic [SEL_W-1:0] pin_sel_q;
  logic             sleep_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_ho_q     <= '0;
      hop_ho_q       <= '0;
      pin_start_en_q <= 1'b0;
      pin_hop_en_q   <= 1'b0;
      pin_sel_q      <= '0;
    end else begin
      if (wr_start_ho) start_ho_q <= wr_data[CNT_W-1:0];
      if (wr_hop_ho)   hop_ho_q   <= wr_data[CNT_W-1:0];
      if (wr_pin_cfg) begin
        pin_start_en_q <= wr_data[BIT_START];
        pin_hop_en_q   <= wr_data[BIT_HOP];
        pin_sel_q      <= wr_data[BIT_SEL_LO +: SEL_W];
      end
    end
  end

  // hardware sync path
  logic [NUM_SYNC-1:0] pin_rise;
  logic                pin_evt;

  sync_pin_front #(
    .NUM_SYNC   (NUM_SYNC),
    .SYNC_STAGES(SYNC_STAGES)
  ) pin_front_i (
    .clk  (clk),
    .rst_n(rst_n),
    .pins (sync_in),
    .rise (pin_rise)
  );

  assign pin_evt = pin_rise[pin_sel_q];

  // trigger combination and counters
  logic soft_start, soft_hop;
  logic start_trig, hop_trig;
  assign soft_start = wr_soft && wr_data[BIT_START];
  assign soft_hop   = wr_soft && wr_data[BIT_HOP];
  assign start_trig = soft_start || (pin_evt && pin_start_en_q);
  assign hop_trig   = soft_hop   || (pin_evt && pin_hop_en_q);

  logic [NUM_EV-1:0]            ev_trig, ev_fire, ev_busy;
  logic [NUM_EV-1:0][CNT_W-1:0] ev_val;
  assign ev_trig[EV_START] = start_trig;
  assign ev_trig[EV_HOP]   = hop_trig;
  assign ev_val[EV_START]  = start_ho_q;
  assign ev_val[EV_HOP]    = hop_ho_q;

  for (genvar e = 0; e < NUM_EV; e++) begin : g_ev
    holdoff_counter #(.CNT_W(CNT_W)) cnt_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .trig    (ev_trig[e]),
      .load_val(ev_val[e]),
      .fire    (ev_fire[e]),
      .busy    (ev_busy[e])
    );
  end

  logic start_fire, hop_fire, start_busy, hop_busy;
  assign start_fire = ev_fire[EV_START];
  assign hop_fire   = ev_fire[EV_HOP];
  assign start_busy = ev_busy[EV_START];
  assign hop_busy   = ev_busy[EV_HOP];

  // sleep state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sleep_q <= 1'b1;
    else sleep_q <= sleep_next(sleep_q, gsleep_wr, lane_of(gsleep_data, CHAN_ID),
                               wr_sleep, wr_data[0], start_fire);
  end

  assign sleep           = sleep_q;
  assign start_pulse     = start_fire;
  assign hop_pulse       = hop_fire;
  assign phase_adj_pulse = start_fire && !sleep_q;

endmodule

// File: rtl/chan_sync_chk.sv
module chan_sync_chk
  import chan_sync_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  wr_en,
  input logic [REG_ADDR_W-1:0] wr_addr,
  input logic                  gsleep_wr,
  input logic                  gsleep_bit,
  input logic                  sleep,
  input logic                  start_pulse,
  input logic                  hop_pulse,
  input logic                  phase_adj_pulse,
  input logic                  start_trig,
  input logic                  hop_trig,
  input logic [CNT_W-1:0]      start_val,
  input logic [CNT_W-1:0]      hop_val,
  input logic                  start_busy
);

  logic local_sleep_wr;
  assign local_sleep_wr = wr_en && (wr_addr == ADDR_SLEEP);

  // R2
  global_sleep_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gsleep_wr |=> (sleep == $past(gsleep_bit)));

  // R2
  sleep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!gsleep_wr && !local_sleep_wr && !start_pulse) |=> $stable(sleep));

  // R6
  start_wakes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_pulse && !gsleep_wr && !local_sleep_wr) |=> !sleep);

  // R7
  phase_adj_awake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase_adj_pulse |-> (start_pulse && !sleep));

  // R3
  start_immediate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_trig && (start_val == CNT_W'(1))) |=> start_pulse);

  // R4
  hop_immediate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hop_trig && (hop_val == CNT_W'(1))) |=> hop_pulse);

  // R5
  start_zero_suppress_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_trig && (start_val == '0) && !start_busy) |=> !start_pulse);

  // R4
  hop_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hop_pulse |=> (!hop_pulse || $past(hop_trig)));

  // R3
  start_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> (!start_pulse || $past(start_trig)));

endmodule

bind chan_sync_ctrl chan_sync_chk #(.CNT_W(CNT_W)) chk_i (
  .clk            (clk),
  .rst_n          (rst_n),
  .wr_en          (wr_en),
  .wr_addr        (wr_addr),
  .gsleep_wr      (gsleep_wr),
  .gsleep_bit     (gsleep_data[CHAN_ID]),
  .sleep          (sleep),
  .start_pulse    (start_pulse),
  .hop_pulse      (hop_pulse),
  .phase_adj_pulse(phase_adj_pulse),
  .start_trig     (start_trig),
  .hop_trig       (hop_trig),
  .start_val      (start_ho_q),
  .hop_val        (hop_ho_q),
  .start_busy     (start_busy)
);

// File: tb/chan_sync_ctrl_tb_top.sv
module chan_sync_ctrl_tb_top;

  localparam int CH = 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        gsleep_wr = 1'b0;
  logic [3:0]  gsleep_data = '0;
  logic [3:0]  sync_in = '0;
  logic        sleep, start_pulse, hop_pulse, phase_adj_pulse;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  int f_st, n_st, f_hp, n_hp, n_pa;

  always #10 clk = ~clk;

  chan_sync_ctrl #(.CHAN_ID(CH)) dut_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .wr_en          (wr_en),
    .wr_addr        (wr_addr),
    .wr_data        (wr_data),
    .gsleep_wr      (gsleep_wr),
    .gsleep_data    (gsleep_data),
    .sync_in        (sync_in),
    .sleep          (sleep),
    .start_pulse    (start_pulse),
    .hop_pulse      (hop_pulse),
    .phase_adj_pulse(phase_adj_pulse)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // drive at a falling edge, return at the next falling edge
  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  // sample outputs; the current falling edge follows 'off' rising edges
  task automatic observe(input int off, input int nobs);
    f_st = 0; n_st = 0; f_hp = 0; n_hp = 0; n_pa = 0;
    for (int i = 0; i < nobs; i++) begin
      if (start_pulse) begin n_st++; if (f_st == 0) f_st = off + i; end
      if (hop_pulse)   begin n_hp++; if (f_hp == 0) f_hp = off + i; end
      if (phase_adj_pulse) n_pa++;
      @(negedge clk);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;

    // R1 reset state
    check("R1", "sleep after reset", sleep, 1);
    observe(0, 8);
    check("R1", "no start pulses", n_st, 0);
    check("R1", "no hop pulses", n_hp, 0);
    check("R1", "no phase pulses", n_pa, 0);
    wr(3'd1, 16'h0003);   // hold-offs are zero: nothing may fire
    observe(1, 6);
    check("R1", "zero hold-off after reset", n_st + n_hp, 0);

    // R2 local and global sleep writes
    wr(3'd0, 16'h0000);
    check("R2", "local write clears", sleep, 0);
    wr(3'd0, 16'h0001);
    check("R2", "local write sets", sleep, 1);
    gsleep_wr = 1'b1; gsleep_data = 4'b1101;   // own lane (1) is 0
    @(negedge clk); gsleep_wr = 1'b0;
    check("R2", "global lane 0 clears", sleep, 0);
    gsleep_wr = 1'b1; gsleep_data = 4'b0010;
    @(negedge clk); gsleep_wr = 1'b0;
    check("R2", "global lane 1 sets", sleep, 1);
    gsleep_wr = 1'b1; gsleep_data = 4'b0000;
    wr(3'd0, 16'h0001);   // same edge: global wins
    gsleep_wr = 1'b0;
    check("R2", "global beats local", sleep, 0);
    wr(3'd0, 16'h0001);

    // R6 wake through a start with V=3
    wr(3'd3, 16'd3);
    wr(3'd1, 16'h0001);                  // index 1
    @(negedge clk);                       // index 2
    check("R6", "asleep before fire", sleep, 1);
    check("R3", "no early start", start_pulse, 0);
    @(negedge clk);                       // index 3
    check("R3", "start at V", start_pulse, 1);
    check("R7", "no phase adj while asleep", phase_adj_pulse, 0);
    check("R6", "sleep still set in fire cycle", sleep, 1);
    @(negedge clk);
    check("R6", "awake after fire", sleep, 0);
    check("R3", "single-cycle start", start_pulse, 0);

    // R7 start while awake
    wr(3'd1, 16'h0001);
    observe(1, 6);
    check("R7", "phase adj count", n_pa, 1);
    check("R7", "start count awake", n_st, 1);
    check("R7", "stays awake", sleep, 0);

    // R3 sweep of start hold-off values
    for (int v = 0; v <= 6; v++) begin
      wr(3'd3, 16'(v));
      wr(3'd1, 16'h0001);
      observe(1, v + 4);
      check("R3", $sformatf("start first V=%0d", v), f_st, v);
      check("R3", $sformatf("start count V=%0d", v), n_st, (v != 0) ? 1 : 0);
      check("R7", $sformatf("phase adj V=%0d", v), n_pa, (v != 0) ? 1 : 0);
    end

    // R4 sweep of hop hold-off values
    for (int v = 0; v <= 6; v++) begin
      wr(3'd4, 16'(v));
      wr(3'd1, 16'h0002);
      observe(1, v + 4);
      check("R4", $sformatf("hop first V=%0d", v), f_hp, v);
      check("R4", $sformatf("hop count V=%0d", v), n_hp, (v != 0) ? 1 : 0);
      check("R4", $sformatf("no start on hop V=%0d", v), n_st, 0);
    end

    // R11 both events from one write
    wr(3'd3, 16'd2);
    wr(3'd4, 16'd5);
    wr(3'd1, 16'h0003);
    observe(1, 9);
    check("R11", "start first", f_st, 2);
    check("R11", "hop first", f_hp, 5);
    check("R11", "one each", n_st + n_hp, 2);

    // R10 retrigger reloads
    wr(3'd3, 16'd5);
    wr(3'd1, 16'h0001);
    idle(2);
    wr(3'd1, 16'h0001);
    observe(1, 9);
    check("R10", "start after reload", f_st, 5);
    check("R10", "single pulse after reload", n_st, 1);

    // R5 zero-valued trigger does not disturb a running count
    wr(3'd3, 16'd4);
    wr(3'd1, 16'h0001);    // index 1
    wr(3'd3, 16'd0);       // index 2
    wr(3'd1, 16'h0001);    // index 3
    observe(3, 6);
    check("R5", "running count kept", f_st, 4);
    check("R5", "one pulse", n_st, 1);

    // R8 each pin selected in turn
    wr(3'd3, 16'd2);
    wr(3'd4, 16'd4);
    for (int p = 0; p < 4; p++) begin
      wr(3'd2, 16'((p << 2) | 3));
      sync_in[p] = 1'b1;
      @(negedge clk);
      sync_in[p] = 1'b0;
      observe(1, 10);
      check("R8", $sformatf("pin %0d start first", p), f_st, 4);
      check("R8", $sformatf("pin %0d hop first", p), f_hp, 6);
      check("R8", $sformatf("pin %0d counts", p), n_st + n_hp, 2);
    end
    wr(3'd2, 16'h0005);    // pin 1, start only
    for (int v = 1; v <= 3; v++) begin
      wr(3'd3, 16'(v));
      sync_in[1] = 1'b1;
      @(negedge clk);
      sync_in[1] = 1'b0;
      observe(1, v + 6);
      check("R8", $sformatf("pin start V=%0d", v), f_st, v + 2);
      check("R8", $sformatf("hop disabled V=%0d", v), n_hp, 0);
    end

    // R9 held pin, unselected pin, disabled enables
    wr(3'd3, 16'd1);
    sync_in[1] = 1'b1;
    observe(0, 14);
    sync_in[1] = 1'b0;
    check("R9", "held pin one trigger", n_st, 1);
    idle(4);
    sync_in[0] = 1'b1; sync_in[2] = 1'b1; sync_in[3] = 1'b1;
    @(negedge clk);
    sync_in = '0;
    observe(1, 8);
    check("R9", "unselected pins ignored", n_st + n_hp, 0);
    wr(3'd2, 16'h0004);    // pin 1, no enables
    sync_in[1] = 1'b1;
    @(negedge clk);
    sync_in[1] = 1'b0;
    observe(1, 8);
    check("R9", "disabled enables ignored", n_st + n_hp, 0);

    // R2/R6 sleep write on the firing edge wins
    wr(3'd0, 16'h0001);
    wr(3'd3, 16'd2);
    wr(3'd1, 16'h0001);    // index 1
    check("R6", "pre-fire no pulse", start_pulse, 0);
    @(negedge clk);        // index 2
    check("R6", "fire visible", start_pulse, 1);
    wr(3'd0, 16'h0001);
    check("R2", "sleep write beats wake", sleep, 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule